// File: doc/BRIEF.md
# Multi-mode Hardware Breakpoint Unit

This block monitors every cycle on a 16-bit CPU bus. On each cycle it compares the address, the data, the transfer direction and the fetch flag against values set through a small write-only configuration port. When a qualifying cycle matches, the block requests either a software interrupt or entry into debug mode. The programmed mode decides which of the two requests is used. The CPU core, the debug monitor, the debug link and the way each request is serviced all sit outside the block and connect only through ports.

The block has three active modes:

- **Software-interrupt dual mode.** Two address-only comparators each request a software interrupt. Only instruction fetches can match.
- **Full debug mode.** One comparator can qualify on address, data and direction, and requests debug entry.
- **Debug dual mode.** Two address-only comparators each request debug entry.

The control bits change meaning with the mode. The data-compare enable doubles as the enable of the second comparator in both dual modes. Each mode ignores its own subset of the qualifiers. While the CPU runs debug monitor code, every match is suppressed.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the mode field reads off (00) and both requests are low. In mode 00 no bus cycle raises a request.
- R2: A configuration write takes effect at the clock edge where `cfg_we_i` is high. The select `cfg_sel_i` chooses the target: 0 = control, 1 = comparator 0 address, 2 = comparator 1 address, 3 = data compare value. The control bits are:
  - [1:0] mode: 00 off, 01 software-interrupt dual, 10 full debug, 11 debug dual
  - [2] fetch-only
  - [3] data enable
  - [4] low-byte enable of comparator 0
  - [5] low-byte enable of comparator 1
  - [6] direction of comparator 0 (1 = read)
  - [7] direction enable of comparator 0
  - [8] direction of comparator 1 (1 = read)
  - [9] direction enable of comparator 1
  - [10] exclude the high data byte
  - [11] exclude the low data byte
- R3: A comparator always compares address bits 15:8. It compares bits 7:0 only when its own low-byte enable is set.
- R4: In software-interrupt dual mode:
  - Only fetch cycles match, whatever the value of the fetch-only bit.
  - The direction bits and the mask bits are ignored.
  - Comparator 0 is always armed. Comparator 1 is armed by the data enable.
- R5: Only software-interrupt dual mode raises `swi_req_o`. Full debug mode and debug dual mode raise only `dbg_req_o`.
- R6: In full debug mode only comparator 0 is used. Its low-byte enable applies. When fetch-only is clear, its direction bit applies if its direction enable is set. The address, low-byte enable and direction bits of comparator 1 have no effect.
- R7: In full debug mode with fetch-only clear:
  - Setting the data enable adds a data compare to the match.
  - Each mask bit removes its byte from that data compare.
- R8: In full debug mode and debug dual mode with fetch-only set:
  - Only fetch cycles match.
  - The data enable, the masks and the direction bits do not affect the match.
- R9: In debug dual mode each comparator applies its own direction bit and direction enable when fetch-only is clear. The data enable arms comparator 1.
- R10: No request is raised for a bus cycle in which `dbg_active_i` is high.
- R11: `dbg_req_o` is raised only for a bus cycle in which `dbg_enabled_i` is high.
- R12: Each qualifying bus cycle (`bus_valid_i` high) produces a request pulse of exactly one clock, in the following cycle. Back-to-back qualifying cycles produce back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_wdata_i | input | 16 | Configuration write data |
| bus_valid_i | input | 1 | A bus cycle is present |
| bus_addr_i | input | 16 | Bus address |
| bus_data_i | input | 16 | Bus data |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_fetch_i | input | 1 | Cycle is an instruction fetch |
| dbg_active_i | input | 1 | CPU is running debug monitor code |
| dbg_enabled_i | input | 1 | Debug controller allows debug entry |
| swi_req_o | output | 1 | Software-interrupt request pulse |
| dbg_req_o | output | 1 | Debug-entry request pulse |

## Verification
The assertions assume two things about the inputs:

- Every bus input, together with the two debug status inputs, is stable and defined around the clock edge that samples it.
- A fetch cycle is always flagged as a read.

The assertions therefore relate each request pulse to the mode, fetch flag and status values seen one cycle earlier. The stimulus honours both assumptions:

- It changes inputs only on the falling edge.
- It drives every fetch with the read flag set.
- It keeps the bus idle during each configuration write, so that no match overlaps a change of mode.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_SWI_DUAL = 2'b01,
    MODE_DBG_FULL = 2'b10,
    MODE_DBG_DUAL = 2'b11
  } bk_mode_e;

  // packed MSB first: mask_lo is bit 11, mode is bits 1:0
  typedef struct packed {
    logic     mask_lo;
    logic     mask_hi;
    logic     rw_en1;
    logic     rw1;
    logic     rw_en0;
    logic     rw0;
    logic     lo_en1;
    logic     lo_en0;
    logic     data_en;
    logic     fetch_only;
    bk_mode_e mode;
  } bk_ctrl_t;

  localparam int CTRL_W  = $bits(bk_ctrl_t);
  localparam int NUM_CMP = 2;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR0 = 2'd1;
  localparam logic [1:0] SEL_ADDR1 = 2'd2;
  localparam logic [1:0] SEL_DATA  = 2'd3;
endpackage

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [1:0]                     cfg_sel_i,
  input  logic [CFG_W-1:0]               cfg_wdata_i,
  output bk_ctrl_t                       ctrl_o,
  output logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_addr_o,
  output logic [DATA_W-1:0]              cmp_data_o
);
  bk_ctrl_t                       ctrl_q;
  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]              data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_sel_i)
        SEL_CTRL:  ctrl_q    <= bk_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
        SEL_ADDR0: addr_q[0] <= cfg_wdata_i[ADDR_W-1:0];
        SEL_ADDR1: addr_q[1] <= cfg_wdata_i[ADDR_W-1:0];
        default:   data_q    <= cfg_wdata_i[DATA_W-1:0];
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp_addr_o = addr_q;
  assign cmp_data_o = data_q;

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_CTRL) |=> (ctrl_q == $past(cfg_wdata_i[CTRL_W-1:0])));

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/bkpt_addr_cmp.sv
`timescale 1ns/1ps
module bkpt_addr_cmp #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cmp_i,
  input  logic              lo_en_i,
  output logic              match_o
);
  logic hi_eq, lo_eq;
  assign hi_eq   = addr_i[ADDR_W-1:LO_W] == cmp_i[ADDR_W-1:LO_W];
  assign lo_eq   = addr_i[LO_W-1:0] == cmp_i[LO_W-1:0];
  assign match_o = hi_eq && (!lo_en_i || lo_eq);
endmodule

// File: rtl/bkpt_data_cmp.sv
`timescale 1ns/1ps
module bkpt_data_cmp #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              mask_hi_i,
  input  logic              mask_lo_i,
  output logic              match_o
);
  logic hi_eq, lo_eq;
  assign hi_eq   = data_i[DATA_W-1:LO_W] == cmp_i[DATA_W-1:LO_W];
  assign lo_eq   = data_i[LO_W-1:0] == cmp_i[LO_W-1:0];
  assign match_o = (mask_hi_i || hi_eq) && (mask_lo_i || lo_eq);
endmodule

// File: rtl/bkpt_unit.sv
`timescale 1ns/1ps
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LO_W   = 8,
  localparam int WIDE_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int CFG_W  = (WIDE_W > CTRL_W) ? WIDE_W : CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_rd_i,
  input  logic              bus_fetch_i,
  input  logic              dbg_active_i,
  input  logic              dbg_enabled_i,
  output logic              swi_req_o,
  output logic              dbg_req_o
);
  bk_ctrl_t                       ctrl;
  logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0]              cmp_data;
  logic [NUM_CMP-1:0]             lo_en, rw_val, rw_en, a_match, rw_ok, hit;
  logic                           d_match, qual, swi_d, dbg_d, swi_q, dbg_q;

  bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ctrl_o      (ctrl),
    .cmp_addr_o  (cmp_addr),
    .cmp_data_o  (cmp_data)
  );

  assign lo_en  = {ctrl.lo_en1, ctrl.lo_en0};
  assign rw_val = {ctrl.rw1, ctrl.rw0};
  assign rw_en  = {ctrl.rw_en1, ctrl.rw_en0};

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    bkpt_addr_cmp #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr_cmp (
      .addr_i  (bus_addr_i),
      .cmp_i   (cmp_addr[k]),
      .lo_en_i (lo_en[k]),
      .match_o (a_match[k])
    );
    assign rw_ok[k] = !rw_en[k] || (bus_rd_i == rw_val[k]);
  end

  bkpt_data_cmp #(.DATA_W(DATA_W), .LO_W(LO_W)) u_data_cmp (
    .data_i    (bus_data_i),
    .cmp_i     (cmp_data),
    .mask_hi_i (ctrl.mask_hi),
    .mask_lo_i (ctrl.mask_lo),
    .match_o   (d_match)
  );

  // mode-dependent meaning of the qualifier bits
  always_comb begin
    hit = '0;
    unique case (ctrl.mode)
      MODE_SWI_DUAL: begin
        hit[0] = a_match[0] && bus_fetch_i;
        hit[1] = a_match[1] && ctrl.data_en && bus_fetch_i;
      end
      MODE_DBG_FULL: begin
        hit[0] = a_match[0] && (ctrl.fetch_only ? bus_fetch_i
                                                : (rw_ok[0] && (!ctrl.data_en || d_match)));
      end
      MODE_DBG_DUAL: begin
        hit[0] = a_match[0] && (ctrl.fetch_only ? bus_fetch_i : rw_ok[0]);
        hit[1] = a_match[1] && ctrl.data_en
                 && (ctrl.fetch_only ? bus_fetch_i : rw_ok[1]);
      end
      default: hit = '0;
    endcase
  end

  assign qual  = bus_valid_i && !dbg_active_i && (|hit);
  assign swi_d = qual && (ctrl.mode == MODE_SWI_DUAL);
  assign dbg_d = qual && dbg_enabled_i
                 && (ctrl.mode == MODE_DBG_FULL || ctrl.mode == MODE_DBG_DUAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q <= 1'b0;
      dbg_q <= 1'b0;
    end else begin
      swi_q <= swi_d;
      dbg_q <= dbg_d;
    end
  end

  assign swi_req_o = swi_q;
  assign dbg_req_o = dbg_q;

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.mode == MODE_OFF) |=> (!swi_req_o && !dbg_req_o));

  p_swi_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_req_o |-> $past(bus_fetch_i));

  p_swi_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_req_o |-> ($past(ctrl.mode) == MODE_SWI_DUAL));

  p_dbg_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |-> ($past(ctrl.mode) == MODE_DBG_FULL || $past(ctrl.mode) == MODE_DBG_DUAL));

  p_single_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swi_req_o && dbg_req_o));

  p_active_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_req_o || dbg_req_o) |-> !$past(dbg_active_i));

  p_dbg_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |-> $past(dbg_enabled_i));

  p_req_after_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_req_o || dbg_req_o) |-> $past(bus_valid_i));
endmodule

// File: tb/bkpt_unit_tb.sv
`timescale 1ns/1ps
module bkpt_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rd = 1'b0;
  logic        bus_fetch = 1'b0;
  logic        dbg_active = 1'b0;
  logic        dbg_enabled = 1'b0;
  logic        swi_req, dbg_req;

  typedef struct {
    bit    swi;
    bit    dbg;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_unit u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_we_i      (cfg_we),
    .cfg_sel_i     (cfg_sel),
    .cfg_wdata_i   (cfg_wdata),
    .bus_valid_i   (bus_valid),
    .bus_addr_i    (bus_addr),
    .bus_data_i    (bus_data),
    .bus_rd_i      (bus_rd),
    .bus_fetch_i   (bus_fetch),
    .dbg_active_i  (dbg_active),
    .dbg_enabled_i (dbg_enabled),
    .swi_req_o     (swi_req),
    .dbg_req_o     (dbg_req)
  );

  task automatic cfg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    bus_valid = 1'b0; dbg_active = 1'b0; dbg_enabled = 1'b1;
    exp_q.push_back('{1'b0, 1'b0, "R2 cfg write quiet"});
  endtask

  task automatic bus(input logic rd, input logic fe, input logic [15:0] a,
                     input logic [15:0] d, input logic act, input logic en,
                     input bit es, input bit ed, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    bus_valid = 1'b1; bus_rd = rd; bus_fetch = fe; bus_addr = a; bus_data = d;
    dbg_active = act; dbg_enabled = en;
    exp_q.push_back('{es, ed, tag});
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0; dbg_active = 1'b0; dbg_enabled = 1'b1;
    exp_q.push_back('{1'b0, 1'b0, tag});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: one expected item per clock edge following its push
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_chk++;
        if (swi_req !== e.swi || dbg_req !== e.dbg) begin
          n_bad++;
          $display("FAIL %s: swi=%0b dbg=%0b expected swi=%0b dbg=%0b",
                   e.tag, swi_req, dbg_req, e.swi, e.dbg);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (swi_req !== 1'b0 || dbg_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: swi=%0b dbg=%0b expected 0 0", swi_req, dbg_req);
    end

    // compare values
    cfg(2'd1, 16'h1234);
    cfg(2'd2, 16'h5678);
    cfg(2'd3, 16'hA55A);
    bus(1, 1, 16'h1234, 16'hA55A, 0, 1, 0, 0, "R1 off after reset");

    // software-interrupt dual: mode 01, lo0, lo1
    cfg(2'd0, 16'h0031);
    bus(1, 1, 16'h1234, 16'h0, 0, 1, 1, 0, "R4 fetch hit cmp0");
    idle("R12 pulse ends");
    bus(1, 0, 16'h1234, 16'h0, 0, 1, 0, 0, "R4 data read no match");
    bus(1, 1, 16'h5678, 16'h0, 0, 1, 0, 0, "R4 cmp1 unarmed");
    bus(1, 1, 16'h1235, 16'h0, 0, 1, 0, 0, "R3 low byte compared");
    cfg(2'd0, 16'h00B9); // + data_en, rw_en0 write-only (ignored)
    bus(1, 1, 16'h5678, 16'h0, 0, 1, 1, 0, "R4 cmp1 armed by data enable");
    bus(1, 1, 16'h1234, 16'h0, 0, 0, 1, 0, "R4 direction ignored");
    bus(1, 1, 16'h1234, 16'h0, 1, 1, 0, 0, "R10 debug active");
    cfg(2'd0, 16'h0029); // lo0 clear
    bus(1, 1, 16'h12FF, 16'h0, 0, 1, 1, 0, "R3 low byte skipped");
    bus(1, 1, 16'h56FF, 16'h0, 0, 1, 0, 0, "R3 cmp1 low byte compared");

    // full debug: mode 10, data_en, lo0
    cfg(2'd0, 16'h001A);
    bus(1, 0, 16'h1234, 16'hA55A, 0, 1, 0, 1, "R5 R7 full hit via dbg");
    bus(1, 0, 16'h1234, 16'hA55A, 0, 0, 0, 0, "R11 debug not enabled");
    bus(1, 0, 16'h1234, 16'hA500, 0, 1, 0, 0, "R7 data mismatch");
    cfg(2'd0, 16'h081A); // mask low byte
    bus(1, 0, 16'h1234, 16'hA500, 0, 1, 0, 1, "R7 low byte masked");
    bus(1, 0, 16'h1234, 16'h0000, 0, 1, 0, 0, "R7 high byte still compared");
    cfg(2'd0, 16'h0C1A); // both masked
    bus(0, 0, 16'h1234, 16'h0000, 0, 1, 0, 1, "R7 both bytes masked");
    bus(1, 0, 16'h5678, 16'hA55A, 0, 1, 0, 0, "R6 cmp1 unused");
    cfg(2'd0, 16'h0092); // rw_en0, write only
    bus(1, 0, 16'h1234, 16'h0, 0, 1, 0, 0, "R6 read rejected");
    bus(0, 0, 16'h1234, 16'h0, 0, 1, 0, 1, "R6 write accepted");
    cfg(2'd0, 16'h0382); // cmp1 rw read-only, lo0 clear (lo1 meaningless)
    bus(0, 0, 16'h12EE, 16'h0, 0, 1, 0, 1, "R6 cmp1 qualifiers no effect");
    cfg(2'd0, 16'h009E); // fetch-only, data_en, rw_en0 write
    bus(1, 0, 16'h1234, 16'hA55A, 0, 1, 0, 0, "R8 non-fetch rejected");
    bus(1, 1, 16'h1234, 16'h0000, 0, 1, 0, 1, "R8 fetch ignores data and rw");

    // debug dual: mode 11, lo0, lo1, data_en
    cfg(2'd0, 16'h003B);
    bus(1, 0, 16'h5678, 16'h0, 0, 1, 0, 1, "R5 R9 dual cmp1 via dbg");
    bus(1, 0, 16'h5678, 16'h0, 1, 1, 0, 0, "R10 debug active dual");
    cfg(2'd0, 16'h02FB); // cmp0 read-only, cmp1 write-only
    bus(1, 0, 16'h1234, 16'h0, 0, 1, 0, 1, "R9 cmp0 read");
    bus(0, 0, 16'h1234, 16'h0, 0, 1, 0, 0, "R9 cmp0 write rejected");
    bus(0, 0, 16'h5678, 16'h0, 0, 1, 0, 1, "R9 cmp1 write");
    bus(1, 0, 16'h5678, 16'h0, 0, 1, 0, 0, "R9 cmp1 read rejected");
    cfg(2'd0, 16'h02FF); // + fetch-only
    bus(0, 0, 16'h5678, 16'h0, 0, 1, 0, 0, "R8 dual non-fetch rejected");
    bus(1, 1, 16'h5678, 16'h0, 0, 1, 0, 1, "R8 dual fetch ignores rw");
    cfg(2'd0, 16'h02F7); // data_en clear
    bus(1, 1, 16'h5678, 16'h0, 0, 1, 0, 0, "R9 cmp1 disarmed");
    bus(1, 1, 16'h1234, 16'h0, 0, 1, 0, 1, "R12 back to back 1");
    bus(1, 1, 16'h1234, 16'h0, 0, 1, 0, 1, "R12 back to back 2");
    idle("R12 pulse ends dual");

    // back to off
    cfg(2'd0, 16'h0038);
    bus(1, 1, 16'h1234, 16'h0, 0, 1, 0, 0, "R1 mode off");
    idle("R1 idle");

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule